// File: doc/BRIEF.md
# Multi-Mode Debug Cycle Counter

This block is a 16-bit counter for an on-chip debug unit. Its behaviour depends on whether the CPU is halted in debug mode or running. It has three working functions. It can measure how many system clock cycles the CPU runs between two halts. It can count down from a value the host loads and request a break when it reaches zero. It can request a break when the program counter equals the value it holds.

The host loads the counter through a write strobe, and only while the CPU is halted in debug mode. The host reads the counter back on `cnt_o`. The break request `brk_o` is a one-cycle pulse to the debug controller, which then halts the CPU. A fourth mode-select code parks the counter, so that it neither counts nor raises a break.

Top module: `dbg_cycle_counter`

## Requirements
- R1: While `rst_ni` is low, `cnt_o` reads 0000h and `brk_o` is low.
- R2: When `ld_we_i` is high in a cycle where `dbg_mode_i` is high, `cnt_o` shows `ld_val_i` after the next clock edge, in every mode. A write while `dbg_mode_i` is low is ignored.
- R3: In cycle-count mode (`mode_i` = 2'b00), the first clock edge at which `dbg_mode_i` is low after being high at the previous edge clears `cnt_o` to 0000h.
- R4: In cycle-count mode, `cnt_o` increments by one at each clock edge at which `dbg_mode_i` is low, except at the exit edge of R3.
- R5: In cycle-count mode, the count saturates at FFFFh and does not wrap to 0000h.
- R6: In countdown mode (`mode_i` = 2'b01), leaving debug mode does not clear the value. `cnt_o` decrements by one at each edge at which `dbg_mode_i` is low, and stays at 0000h once it reaches zero.
- R7: In any mode, while `dbg_mode_i` is high and no write occurs, `cnt_o` holds its value.
- R8: In countdown mode, `brk_o` is high for exactly the one cycle in which `cnt_o` first shows 0000h after a decrement from 0001h. It does not fire again until a new value is loaded.
- R9: In match mode (`mode_i` = 2'b10), the value is never cleared and does not count. `brk_o` is high for one cycle after the first clock edge at which `pc_i` equals `cnt_o` with `dbg_mode_i` low. It stays low while the match persists, and there is no break while `dbg_mode_i` is high.
- R10: In park mode (`mode_i` = 2'b11), `cnt_o` holds outside debug mode. `brk_o` is never raised in park mode or in cycle-count mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_mode_i | input | 1 | High while the CPU is halted in debug mode |
| mode_i | input | 2 | Function select: 00 cycle count, 01 countdown, 10 PC match, 11 park |
| ld_val_i | input | 16 | Value loaded by the host |
| ld_we_i | input | 1 | Host write strobe, honoured only in debug mode |
| pc_i | input | 16 | Current program counter |
| cnt_o | output | 16 | Counter value for host readback |
| brk_o | output | 1 | One-cycle break request |

## Verification
Cycle-count runs are split by halts. This shows the difference between clearing at the exit edge and freezing while halted. A run is also started just below FFFFh, so that saturation is told apart from wrap-around. The countdown is loaded, run to zero, reloaded, and halted part way through. This checks that the value survives a halt and that the break fires only once per load. In match mode the program counter is swept across the stored value, held on it, moved away and back, and parked on it during a halt. This separates a first-cycle pulse from a level output and from a break raised during a halt. A long phase of random stimulus then mixes modes, halts and writes, including writes made while the CPU runs.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int unsigned CNT_W = 16;

  typedef enum logic [1:0] {
    MODE_CYCLE = 2'b00,
    MODE_DOWN  = 2'b01,
    MODE_MATCH = 2'b10,
    MODE_PARK  = 2'b11
  } dcc_mode_e;
endpackage

// File: rtl/dcc_dbg_track.sv
module dcc_dbg_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dbg_mode_i,
  output logic dbg_exit_o
);
  logic dbg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dbg_q <= 1'b0;
    else         dbg_q <= dbg_mode_i;
  end

  // first running cycle after a halt
  assign dbg_exit_o = dbg_q & ~dbg_mode_i;

  p_exit_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_exit_o |=> !dbg_exit_o);
endmodule

// File: rtl/dcc_counter.sv
module dcc_counter
  import dcc_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  dcc_mode_e    mode_i,
  input  logic         dbg_mode_i,
  input  logic         dbg_exit_i,
  input  logic         ld_we_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_hit_o
);
  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (dbg_mode_i) begin
      if (ld_we_i) cnt_d = ld_val_i;
    end else begin
      unique case (mode_i)
        MODE_CYCLE: begin
          if (dbg_exit_i)             cnt_d = '0;
          else if (cnt_q != CNT_MAX)  cnt_d = cnt_q + CNT_ONE;
        end
        MODE_DOWN: begin
          if (cnt_q != '0) cnt_d = cnt_q - CNT_ONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign zero_hit_o = !dbg_mode_i && (mode_i == MODE_DOWN) && (cnt_q == CNT_ONE);

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_mode_i && ld_we_i) |=> cnt_o == $past(ld_val_i));
  p_exit_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CYCLE && dbg_exit_i) |=> cnt_o == '0);
  p_cycle_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CYCLE && !dbg_mode_i && !dbg_exit_i && cnt_o != CNT_MAX)
      |=> cnt_o == $past(cnt_o) + CNT_ONE);
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CYCLE && !dbg_mode_i && !dbg_exit_i && cnt_o == CNT_MAX)
      |=> cnt_o == CNT_MAX);
  p_down_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DOWN && !dbg_mode_i && cnt_o != '0)
      |=> cnt_o == $past(cnt_o) - CNT_ONE);
  p_down_floor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DOWN && !dbg_mode_i && cnt_o == '0) |=> cnt_o == '0);
  p_halt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_mode_i && !ld_we_i) |=> $stable(cnt_o));
  p_park_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {MODE_PARK, MODE_MATCH} && !dbg_mode_i) |=> $stable(cnt_o));
endmodule

// File: rtl/dcc_break.sv
module dcc_break
  import dcc_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  dcc_mode_e    mode_i,
  input  logic         dbg_mode_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] pc_i,
  input  logic         zero_hit_i,
  output logic         brk_o
);
  logic match_now, match_q, brk_q;

  assign match_now = (mode_i == MODE_MATCH) && !dbg_mode_i && (pc_i == cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      match_q <= match_now;
      brk_q   <= zero_hit_i | (match_now & ~match_q);
    end
  end

  assign brk_o = brk_q;

  p_down_brk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_hit_i |=> brk_o && cnt_i == '0);
  p_down_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_DOWN && cnt_i == '0) |=> !brk_o);
  p_match_halt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_MATCH && dbg_mode_i) |=> !brk_o);
  p_no_brk_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {MODE_CYCLE, MODE_PARK}) |=> !brk_o);
endmodule

// File: rtl/dbg_cycle_counter.sv
module dbg_cycle_counter
  import dcc_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dbg_mode_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         ld_we_i,
  input  logic [W-1:0] pc_i,
  output logic [W-1:0] cnt_o,
  output logic         brk_o
);
  dcc_mode_e mode;
  logic      dbg_exit;
  logic      zero_hit;

  assign mode = dcc_mode_e'(mode_i);

  dcc_dbg_track u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dbg_mode_i (dbg_mode_i),
    .dbg_exit_o (dbg_exit)
  );

  dcc_counter #(.W(W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .dbg_mode_i (dbg_mode_i),
    .dbg_exit_i (dbg_exit),
    .ld_we_i    (ld_we_i),
    .ld_val_i   (ld_val_i),
    .cnt_o      (cnt_o),
    .zero_hit_o (zero_hit)
  );

  dcc_break #(.W(W)) u_brk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .dbg_mode_i (dbg_mode_i),
    .cnt_i      (cnt_o),
    .pc_i       (pc_i),
    .zero_hit_i (zero_hit),
    .brk_o      (brk_o)
  );

  always_comb begin
    p_reset_r1: assert (rst_ni || (cnt_o == '0 && !brk_o));
  end
endmodule

// File: tb/tb_dbg_cycle_counter.sv
`timescale 1ns/1ps
module tb_dbg_cycle_counter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dbg = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] ld = '0;
  logic        we = 1'b0;
  logic [15:0] pc = '0;
  logic [15:0] cnt;
  logic        brk;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] m_cnt = '0;
  logic        m_dbg_q = 1'b0;
  logic        m_match_q = 1'b0;
  logic        m_brk = 1'b0;

  always #4 clk = ~clk;

  dbg_cycle_counter dut (
    .clk_i(clk), .rst_ni(rst_ni), .dbg_mode_i(dbg), .mode_i(mode),
    .ld_val_i(ld), .ld_we_i(we), .pc_i(pc), .cnt_o(cnt), .brk_o(brk)
  );

  task automatic model_tick();
    logic        leaving = m_dbg_q && !dbg;
    logic [15:0] nxt = m_cnt;
    logic        nb = 1'b0;
    logic        nm = 1'b0;
    if (dbg) begin
      if (we) nxt = ld;
    end else begin
      case (mode)
        2'b00: if (leaving) nxt = 16'h0000; else if (m_cnt != 16'hFFFF) nxt = m_cnt + 16'd1;
        2'b01: begin
          if (m_cnt != 16'h0000) nxt = m_cnt - 16'd1;
          nb = (m_cnt == 16'h0001);
        end
        2'b10: begin
          nm = (pc == m_cnt);
          nb = nm && !m_match_q;
        end
        default: ;
      endcase
    end
    m_cnt = nxt; m_brk = nb; m_match_q = nm; m_dbg_q = dbg;
  endtask

  task automatic compare(string tag);
    vectors++;
    if (cnt !== m_cnt || brk !== m_brk) begin
      fails++;
      $display("FAIL %s t=%0t cnt=%h brk=%b expected cnt=%h brk=%b",
               tag, $time, cnt, brk, m_cnt, m_brk);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_tick();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_ni = 1'b1;

    // R4 free count from reset, R2 write while running ignored
    mode = 2'b00;
    run(6, "R4 count");
    we = 1'b1; ld = 16'hBEEF;
    run(2, "R2 write ignored while running");
    we = 1'b0;
    // R7 halt freezes, R2 load in debug
    dbg = 1'b1;
    run(5, "R7 halt hold");
    we = 1'b1; ld = 16'h1234;
    step("R2 load");
    we = 1'b0;
    run(2, "R7 hold after load");
    dbg = 1'b0;
    step("R3 exit clear");
    run(20, "R4 count after exit");

    // R10 park, then R5 saturation
    dbg = 1'b1; mode = 2'b11;
    we = 1'b1; ld = 16'hFFF0; step("R2 load park");
    we = 1'b0; dbg = 1'b0;
    run(6, "R10 park hold");
    mode = 2'b00;
    run(30, "R5 saturate");

    // R6 / R8 countdown
    dbg = 1'b1; mode = 2'b01;
    we = 1'b1; ld = 16'd10; step("R2 load down");
    we = 1'b0; dbg = 1'b0;
    run(18, "R8 countdown break");
    dbg = 1'b1; we = 1'b1; ld = 16'd30; step("R2 reload");
    we = 1'b0; dbg = 1'b0;
    run(5, "R6 decrement");
    dbg = 1'b1;
    run(5, "R7 down freeze");
    dbg = 1'b0;
    run(35, "R6 no clear on exit");

    // R9 match
    dbg = 1'b1; mode = 2'b10;
    we = 1'b1; ld = 16'h0040; step("R2 load match");
    we = 1'b0; dbg = 1'b0;
    for (int a = 16'h0030; a < 16'h0050; a++) begin
      pc = 16'(a); step("R9 sweep");
    end
    pc = 16'h0040; run(6, "R9 held match");
    pc = 16'h0041; run(2, "R9 away");
    pc = 16'h0040; run(3, "R9 re-match");
    pc = 16'h0000; run(2, "R9 away");
    dbg = 1'b1; pc = 16'h0040; run(4, "R9 halt suppress");
    dbg = 1'b0; run(3, "R9 match after halt");

    // R10 no break in cycle/park even with pc == cnt
    mode = 2'b11; pc = cnt; run(4, "R10 park no break");

    // mixed random stimulus
    for (int i = 0; i < 3000; i++) begin
      dbg  = ($urandom_range(0, 9) < 3);
      mode = 2'($urandom_range(0, 3));
      we   = ($urandom_range(0, 3) == 0);
      ld   = 16'($urandom_range(0, 40));
      pc   = 16'($urandom_range(0, 40));
      step("R2 R6 R9 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule